// File: doc/BRIEF.md
# Sized Unary Negate / Clear / Complement Unit

This block applies one of four single-operand operations to a 32-bit value: a two's-complement negation, a negation that also subtracts an incoming extend bit (for multi-word arithmetic), a clear, and a bitwise complement. The operation works on a byte, a word or a long slice of the operand, selected by a size code. Condition flags (extend, negative, zero, overflow, carry) are computed from the selected slice only. Bits of the operand above the slice pass through unchanged. The unit also reports how many bus cycles the operation costs. That cost depends on the operand width and on whether the operand lives in a register or in memory.

A caller presents the operand, the size and operation codes, the location flag and the current flags, and pulses `go`. The block captures everything at that clock edge. It presents the registered result, the new flags, the illegal-size indication and the cycle cost on the following cycle, and raises `done` for that cycle.

A two-state controller sequences the work:
- ST_IDLE waits for `go`.
- Transition IDLE_TO_DONE is taken on `go` and captures the outputs.
- ST_DONE presents `done`.
- Transition DONE_TO_DONE is taken when `go` is held high, so a new capture happens while the previous result is being shown.
- Transition DONE_TO_IDLE is taken when `go` is low.

Outputs hold their values in both states until the next capture.

Top module: `unary_alu`

## Requirements
- R1: After reset is released, `result`, all five flag outputs, `bad_size`, `cyc_cnt` and `done` are zero.
- R2: When `go` is high at a rising edge, every output reflects that cycle's inputs from the next cycle on, and `done` is 1 for that cycle. A cycle without `go` drops `done` to 0 and leaves all other outputs unchanged.
- R3: Operation code 2 (negate) gives the slice (0 − a) mod 2^w. N is the slice's sign bit and Z is 1 when the slice is zero. C is 1 when the operand slice is nonzero. V is 1 when both the operand slice and the result slice have their sign bit set. X is set equal to C.
- R4: Operation code 0 (negate with extend) gives (0 − a − X) mod 2^w. C is 1 when the operand slice is nonzero or X is 1, and X is set equal to C. N and V follow the R3 rules. Z becomes 0 for a nonzero slice and otherwise keeps `z_in`, so Z is never set by this operation.
- R5: Operation code 1 (clear) gives a zero slice with N=0, Z=1, V=0, C=0 and X equal to `x_in`, whatever the operand.
- R6: Operation code 3 (complement) gives the inverted slice. N and Z are taken from the result, V and C are 0, and X equals `x_in`.
- R7: Size code 0 selects bits 7:0, code 1 selects bits 15:0 and code 2 selects bits 31:0. Result bits above the slice equal the operand's bits, and flags depend on the slice only.
- R8: Size code 3 is illegal. It sets `bad_size`=1, returns the operand unchanged, copies all five flag inputs to the flag outputs and reports a cost of 0. A legal size gives `bad_size`=0.
- R9: `cyc_cnt` is 4 for byte or word and 6 for long. The value is doubled when `in_mem` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Capture strobe for the operation on the other inputs |
| opnd | input | 32 | Operand |
| size_sel | input | 2 | Slice size: 0 byte, 1 word, 2 long, 3 illegal |
| op_sel | input | 2 | 0 negate with extend, 1 clear, 2 negate, 3 complement |
| in_mem | input | 1 | Operand is in memory (1) or a register (0) |
| x_in | input | 1 | Incoming extend flag |
| n_in | input | 1 | Incoming negative flag |
| z_in | input | 1 | Incoming zero flag |
| v_in | input | 1 | Incoming overflow flag |
| c_in | input | 1 | Incoming carry flag |
| result | output | 32 | Result with untouched upper bits |
| x_out | output | 1 | New extend flag |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| v_out | output | 1 | New overflow flag |
| c_out | output | 1 | New carry flag |
| bad_size | output | 1 | Illegal size code was captured |
| cyc_cnt | output | 4 | Cycle cost of the captured operation |
| done | output | 1 | Outputs hold a result captured on the previous edge |

## Verification
Two functions can fall in the same cycle: the ST_DONE presentation of one result and the capture of the next operation when `go` stays high. The bench provokes this by holding `go` across two consecutive edges with different operations. At each step it confirms that `done` never drops and that each result matches its own operation's arithmetic rather than a mix of the two. The bench also sweeps every operation, size, location and incoming X/Z value over a set of edge operands, and compares each output against values it computes itself.

// File: rtl/unary_alu_pkg.sv
package unary_alu_pkg;

    typedef enum logic [1:0] {
        OP_NEGX = 2'd0,
        OP_CLR  = 2'd1,
        OP_NEG  = 2'd2,
        OP_NOT  = 2'd3
    } uop_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } usize_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ustate_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } uflags_t;

endpackage

// File: rtl/unary_alu_lane.sv
module unary_alu_lane
    import unary_alu_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [LW-1:0] a,
    input  uop_e          op,
    input  logic          x_in,
    input  logic          z_in,
    output logic [LW-1:0] r,
    output uflags_t       fl
);
    logic [LW:0] diff;
    logic        xterm;

    always_comb begin
        xterm = (op == OP_NEGX) & x_in;
        diff  = {(LW+1){1'b0}} - {1'b0, a} - {{LW{1'b0}}, xterm};
        r     = '0;
        fl    = '0;
        unique case (op)
            OP_NEGX: begin
                r    = diff[LW-1:0];
                fl.c = diff[LW];
                fl.x = diff[LW];
                fl.n = diff[LW-1];
                fl.v = a[LW-1] & diff[LW-1];
                fl.z = (diff[LW-1:0] == '0) ? z_in : 1'b0;
            end
            OP_CLR: begin
                r    = '0;
                fl.x = x_in;
                fl.z = 1'b1;
            end
            OP_NEG: begin
                r    = diff[LW-1:0];
                fl.c = diff[LW];
                fl.x = diff[LW];
                fl.n = diff[LW-1];
                fl.v = a[LW-1] & diff[LW-1];
                fl.z = (diff[LW-1:0] == '0);
            end
            OP_NOT: begin
                r    = ~a;
                fl.x = x_in;
                fl.n = ~a[LW-1];
                fl.z = (a == {LW{1'b1}});
            end
            default: begin
                r  = '0;
                fl = '0;
            end
        endcase
    end
endmodule

// File: rtl/unary_alu_core.sv
module unary_alu_core
    import unary_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_LANES = 3
) (
    input  logic [DATA_W-1:0] opnd,
    input  usize_e            size,
    input  uop_e              op,
    input  logic              x_in,
    input  logic              z_in,
    output logic [DATA_W-1:0] res,
    output uflags_t           fl
);
    logic [DATA_W-1:0] lane_res [N_LANES];
    uflags_t           lane_fl  [N_LANES];
    logic [DATA_W-1:0] mask;

    for (genvar gi = 0; gi < N_LANES; gi++) begin : g_lane
        localparam int LW = 8 << gi;
        logic [LW-1:0] lr;
        unary_alu_lane #(.LW(LW)) lane_i (
            .a    (opnd[LW-1:0]),
            .op   (op),
            .x_in (x_in),
            .z_in (z_in),
            .r    (lr),
            .fl   (lane_fl[gi])
        );
        assign lane_res[gi] = DATA_W'(lr);
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: begin mask = DATA_W'(8'hFF);      res = lane_res[0]; fl = lane_fl[0]; end
            SZ_WORD: begin mask = DATA_W'(16'hFFFF);   res = lane_res[1]; fl = lane_fl[1]; end
            SZ_LONG: begin mask = {DATA_W{1'b1}};      res = lane_res[2]; fl = lane_fl[2]; end
            default: begin mask = '0;                  res = '0;          fl = '0;         end
        endcase
        res = (opnd & ~mask) | (res & mask);
    end
endmodule

// File: rtl/unary_alu_cost.sv
module unary_alu_cost
    import unary_alu_pkg::*;
#(
    parameter int CYC_W      = 4,
    parameter int SHORT_COST = 4,
    parameter int LONG_COST  = 6
) (
    input  usize_e           size,
    input  logic             in_mem,
    output logic [CYC_W-1:0] cyc
);
    logic [CYC_W-1:0] base;

    always_comb begin
        unique case (size)
            SZ_BYTE, SZ_WORD: base = CYC_W'(SHORT_COST);
            SZ_LONG:          base = CYC_W'(LONG_COST);
            default:          base = '0;
        endcase
        cyc = in_mem ? (base << 1) : base;
    end
endmodule

// File: rtl/unary_alu.sv
module unary_alu
    import unary_alu_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CYC_W      = 4,
    parameter int SHORT_COST = 4,
    parameter int LONG_COST  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] opnd,
    input  logic [1:0]        size_sel,
    input  logic [1:0]        op_sel,
    input  logic              in_mem,
    input  logic              x_in,
    input  logic              n_in,
    input  logic              z_in,
    input  logic              v_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] result,
    output logic              x_out,
    output logic              n_out,
    output logic              z_out,
    output logic              v_out,
    output logic              c_out,
    output logic              bad_size,
    output logic [CYC_W-1:0]  cyc_cnt,
    output logic              done
);
    localparam int N_LANES = 3;

    usize_e            size;
    uop_e              op;
    logic [DATA_W-1:0] core_res;
    uflags_t           core_fl;
    uflags_t           in_fl;
    uflags_t           fl_q;
    logic [CYC_W-1:0]  cost;
    ustate_e           state_q;
    ustate_e           state_d;

    assign size  = usize_e'(size_sel);
    assign op    = uop_e'(op_sel);
    assign in_fl = '{x: x_in, n: n_in, z: z_in, v: v_in, c: c_in};

    unary_alu_core #(.DATA_W(DATA_W), .N_LANES(N_LANES)) core_i (
        .opnd (opnd),
        .size (size),
        .op   (op),
        .x_in (x_in),
        .z_in (z_in),
        .res  (core_res),
        .fl   (core_fl)
    );

    unary_alu_cost #(.CYC_W(CYC_W), .SHORT_COST(SHORT_COST), .LONG_COST(LONG_COST)) cost_i (
        .size   (size),
        .in_mem (in_mem),
        .cyc    (cost)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = go ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = go ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            fl_q     <= '0;
            bad_size <= 1'b0;
            cyc_cnt  <= '0;
        end else if (go) begin
            if (size == SZ_BAD) begin
                result   <= opnd;
                fl_q     <= in_fl;
                bad_size <= 1'b1;
                cyc_cnt  <= '0;
            end else begin
                result   <= core_res;
                fl_q     <= core_fl;
                bad_size <= 1'b0;
                cyc_cnt  <= cost;
            end
        end
    end

    assign done  = (state_q == ST_DONE);
    assign x_out = fl_q.x;
    assign n_out = fl_q.n;
    assign z_out = fl_q.z;
    assign v_out = fl_q.v;
    assign c_out = fl_q.c;
endmodule

// File: rtl/unary_alu_chk.sv
module unary_alu_chk #(
    parameter int DATA_W = 32,
    parameter int CYC_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              go,
    input logic [DATA_W-1:0] opnd,
    input logic [1:0]        size_sel,
    input logic [1:0]        op_sel,
    input logic              x_in,
    input logic              n_in,
    input logic              z_in,
    input logic              v_in,
    input logic              c_in,
    input logic [DATA_W-1:0] result,
    input logic              x_out,
    input logic              n_out,
    input logic              z_out,
    input logic              v_out,
    input logic              c_out,
    input logic              bad_size,
    input logic [CYC_W-1:0]  cyc_cnt,
    input logic              done
);
    a_r2_done_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> done);

    a_r2_hold_without_go: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (!done && $stable(result) && $stable(cyc_cnt) && $stable(bad_size)));

    a_r3_neg_x_tracks_c: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == 2'd2 && size_sel != 2'd3) |=> (x_out == c_out));

    a_r4_negx_never_sets_z: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == 2'd0 && size_sel != 2'd3 && !z_in) |=> !z_out);

    a_r5_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == 2'd1 && size_sel != 2'd3) |=>
            (z_out && !n_out && !v_out && !c_out && x_out == $past(x_in)));

    a_r6_not_clears_vc: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_sel == 2'd3 && size_sel != 2'd3) |=> (!v_out && !c_out));

    a_r8_illegal_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (go && size_sel == 2'd3) |=>
            (bad_size && result == $past(opnd) && cyc_cnt == '0 &&
             x_out == $past(x_in) && n_out == $past(n_in) && z_out == $past(z_in) &&
             v_out == $past(v_in) && c_out == $past(c_in)));

    a_r9_cost_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (go && size_sel != 2'd3) |=>
            (!bad_size && (cyc_cnt == 4 || cyc_cnt == 6 || cyc_cnt == 8 || cyc_cnt == 12)));
endmodule

bind unary_alu unary_alu_chk #(.DATA_W(DATA_W), .CYC_W(CYC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .opnd     (opnd),
    .size_sel (size_sel),
    .op_sel   (op_sel),
    .x_in     (x_in),
    .n_in     (n_in),
    .z_in     (z_in),
    .v_in     (v_in),
    .c_in     (c_in),
    .result   (result),
    .x_out    (x_out),
    .n_out    (n_out),
    .z_out    (z_out),
    .v_out    (v_out),
    .c_out    (c_out),
    .bad_size (bad_size),
    .cyc_cnt  (cyc_cnt),
    .done     (done)
);

// File: tb/unary_alu_tb_top.sv
`timescale 1ns/1ps
module unary_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [31:0] opnd = '0;
    logic [1:0]  size_sel = '0;
    logic [1:0]  op_sel = '0;
    logic        in_mem = 1'b0;
    logic        x_in = 1'b0, n_in = 1'b0, z_in = 1'b0, v_in = 1'b0, c_in = 1'b0;
    logic [31:0] result;
    logic        x_out, n_out, z_out, v_out, c_out, bad_size, done;
    logic [3:0]  cyc_cnt;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    unary_alu dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .opnd(opnd), .size_sel(size_sel),
        .op_sel(op_sel), .in_mem(in_mem), .x_in(x_in), .n_in(n_in), .z_in(z_in),
        .v_in(v_in), .c_in(c_in), .result(result), .x_out(x_out), .n_out(n_out),
        .z_out(z_out), .v_out(v_out), .c_out(c_out), .bad_size(bad_size),
        .cyc_cnt(cyc_cnt), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // expected outputs computed arithmetically from the requirements
    task automatic model(input logic [1:0] op, input logic [1:0] sz, input logic mem,
                         input logic [31:0] a32, input logic [4:0] fin,
                         output logic [31:0] eres, output logic [4:0] efl,
                         output logic [3:0] ecyc, output logic ebad);
        int          w;
        logic [63:0] mask, a, r;
        logic        ex, en, ez, ev, ec;
        if (sz == 2'd3) begin
            eres = a32; efl = fin; ecyc = 4'd0; ebad = 1'b1;
            return;
        end
        ebad = 1'b0;
        w    = 8 << sz;
        mask = (64'd1 << w) - 64'd1;
        a    = {32'd0, a32} & mask;
        ex = fin[4]; ez = fin[2]; en = 1'b0; ev = 1'b0; ec = 1'b0;
        case (op)
            2'd2: begin
                r  = (64'd0 - a) & mask;
                ec = (a != 0); ex = ec; en = r[w-1]; ez = (r == 0);
                ev = a[w-1] & r[w-1];
            end
            2'd0: begin
                r  = (64'd0 - a - {63'd0, fin[4]}) & mask;
                ec = (a != 0) || fin[4]; ex = ec; en = r[w-1];
                ev = a[w-1] & r[w-1];
                ez = (r != 0) ? 1'b0 : fin[2];
            end
            2'd1: begin
                r = 64'd0; ez = 1'b1;
            end
            default: begin
                r  = (~a) & mask;
                en = r[w-1]; ez = (r == 0);
            end
        endcase
        eres = (a32 & ~mask[31:0]) | r[31:0];
        efl  = {ex, en, ez, ev, ec};
        ecyc = (sz == 2'd2) ? 4'd6 : 4'd4;
        if (mem) ecyc = ecyc << 1;
    endtask

    function automatic string op_tag(input logic [1:0] op, input logic [1:0] sz);
        if (sz == 2'd3) return "R8";
        case (op)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R3";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input logic [1:0] op, input logic [1:0] sz, input logic mem,
                         input logic [31:0] a32, input logic [4:0] fin);
        op_sel = op; size_sel = sz; in_mem = mem; opnd = a32;
        {x_in, n_in, z_in, v_in, c_in} = fin;
        go = 1'b1;
    endtask

    task automatic verify(input logic [1:0] op, input logic [1:0] sz, input logic mem,
                          input logic [31:0] a32, input logic [4:0] fin);
        logic [31:0] eres;
        logic [4:0]  efl;
        logic [3:0]  ecyc;
        logic        ebad;
        string       t;
        model(op, sz, mem, a32, fin, eres, efl, ecyc, ebad);
        t = op_tag(op, sz);
        check(done == 1'b1, "R2 done", done, 1);
        check(result[7:0] == eres[7:0], {t, " result low"}, result, eres);
        check(result == eres, {t, "/R7 result full"}, result, eres);
        check({x_out, n_out, z_out, v_out, c_out} == efl, {t, "/R7 flags xnzvc"},
              {x_out, n_out, z_out, v_out, c_out}, efl);
        check(cyc_cnt == ecyc, "R9 cycles", cyc_cnt, ecyc);
        check(bad_size == ebad, "R8 bad_size", bad_size, ebad);
    endtask

    initial begin : watchdog
        #(400_000ns);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pats [12];
        logic [31:0] held;
        pats[0]  = 32'h0000_0000; pats[1]  = 32'h0000_0001; pats[2]  = 32'hA5A5_A580;
        pats[3]  = 32'h1234_567F; pats[4]  = 32'hCAFE_8000; pats[5]  = 32'h8000_0000;
        pats[6]  = 32'hFFFF_FFFF; pats[7]  = 32'h7FFF_FFFF; pats[8]  = 32'h00FF_7FFF;
        pats[9]  = 32'hDEAD_BE00; pats[10] = 32'h0001_0000; pats[11] = 32'h5555_00FF;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(result == 0, "R1 result", result, 0);
        check({x_out, n_out, z_out, v_out, c_out} == 0, "R1 flags",
              {x_out, n_out, z_out, v_out, c_out}, 0);
        check(bad_size == 0 && cyc_cnt == 0 && done == 0, "R1 status",
              {bad_size, cyc_cnt, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int op = 0; op < 4; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int mem = 0; mem < 2; mem++)
                    for (int xz = 0; xz < 4; xz++)
                        for (int p = 0; p < 12; p++) begin
                            logic [4:0] fin;
                            fin = {xz[1], p[0], xz[0], p[1], p[2]};
                            apply(op[1:0], sz[1:0], mem[0], pats[p], fin);
                            @(negedge clk);
                            go = 1'b0;
                            verify(op[1:0], sz[1:0], mem[0], pats[p], fin);
                        end

        // R2 hold: no go, outputs must not move and done drops
        held = result;
        opnd = 32'h0BAD_F00D; op_sel = 2'd2; size_sel = 2'd2;
        @(negedge clk);
        check(done == 1'b0, "R2 done low", done, 0);
        check(result == held, "R2 result held", result, held);

        // R2 back-to-back: presentation and capture in one cycle
        apply(2'd0, 2'd0, 1'b0, 32'h0000_0000, 5'b10100);
        @(negedge clk);
        verify(2'd0, 2'd0, 1'b0, 32'h0000_0000, 5'b10100);
        apply(2'd3, 2'd1, 1'b1, 32'h1234_00FF, 5'b00000);
        @(negedge clk);
        verify(2'd3, 2'd1, 1'b1, 32'h1234_00FF, 5'b00000);
        apply(2'd1, 2'd2, 1'b1, 32'hFFFF_FFFF, 5'b11011);
        @(negedge clk);
        go = 1'b0;
        verify(2'd1, 2'd2, 1'b1, 32'hFFFF_FFFF, 5'b11011);
        @(negedge clk);
        check(done == 1'b0, "R2 done after burst", done, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule